// File: doc/BRIEF.md
# Double-Buffered SPI Master Engine

This block is a three-wire SPI master that moves fixed 8-bit frames over a serial clock it generates itself. It drives the outgoing data line, samples the incoming data line and produces the serial clock. Clock polarity, clock phase and bit order are set on configuration inputs, so the block can talk to a slave in any of the four usual SPI modes. A programmable divider sets the serial clock period to 2×(N+1) system clocks. The fastest setting is therefore half the system clock.

The transmit side has a one-byte holding slot in front of the shift register. Software, or an upstream engine, can load the next byte while the current one is still shifting. When a byte is waiting at the end of a frame, the next frame starts on the very next half-period, with no idle serial-clock time in between. Each completed received byte lands in a holding register, and a one-cycle valid pulse announces it. Configuration inputs are expected to change only while the engine is idle and the slot is empty.

Top module: `spi_master_engine`

## Requirements
- R1: While idle, the serial clock rests at the polarity level `cfg_cpol`. Each bit has two halves: the first at the polarity level, the second at its inverse. The leading edge enters the second half and the trailing edge leaves it. With `cfg_cpha`=0, a bit is put on `mosi` before its leading edge and `miso` is sampled on the leading edge. With `cfg_cpha`=1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R2: `cfg_lsb_first`=1 sends and receives data bit 0 first. `cfg_lsb_first`=0 sends and receives bit 7 first. The received bit in each position lands in the same bit index of `rx_data`.
- R3: Each half of a serial clock period lasts `cfg_div`+1 system clocks. With `cfg_div`=0, the serial clock runs at half the system clock.
- R4: `tx_ready` is 1 exactly when the holding slot is empty. A byte is accepted on a clock edge where both `tx_valid` and `tx_ready` are 1. A `tx_valid` presented while `tx_ready` is 0 is ignored, and that byte is never transmitted.
- R5: If the engine is idle when a byte is accepted, it moves the byte into the shift register on the next clock edge. At that edge `busy` rises and `tx_ready` returns to 1. The first half-period starts then.
- R6: If a byte is waiting when the trailing edge of the eighth bit occurs, that byte enters the shift register on the same edge. Its first half-period follows directly, `busy` stays 1 and `tx_ready` returns to 1 on that edge.
- R7: `rx_valid` is a one-cycle pulse raised with the trailing edge of each frame's eighth bit. At that time `rx_data` holds the byte received in that frame, and `rx_data` stays unchanged until the next pulse.
- R8: When no byte is waiting at the end of a frame, `busy` falls on the trailing edge of the last bit. `mosi` then holds the frame's last transmitted bit until a new frame drives it.
- R9: After reset, `tx_ready`=1, `busy`=0, `rx_valid`=0, `sclk`=0, `mosi`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Holding slot empty, byte can be accepted |
| rx_valid | output | 1 | One-cycle pulse when a received byte is complete |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | A frame is shifting |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench models the serial timing behaviourally and compares the clock, busy, ready and valid outputs on every cycle. An independent slave model captures `mosi` and drives `miso` on the edges the selected mode names. It sweeps all four modes, both bit orders and two divider values, including the half-system-clock rate. With these it catches a phase swap, which would corrupt captured bytes, a reversed bit order, and an off-by-one half-period, which would shift every clock edge. Back-to-back bytes probe the gapless hand-over. A design that idled between frames would show `busy` dropping and the serial clock stretching. A write offered while the slot is full checks that an overwriting design would send the wrong byte. Idle checks confirm the clock level and that `mosi` keeps its last bit.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int FRAME_BITS = 8;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;

    // Shift engine state, registered as one word.
    typedef struct packed {
        logic     active;    // a frame is shifting
        logic     half;      // 0: first half (idle level), 1: second half
        bit_idx_t bitn;      // current bit number within the frame
        frame_t   tx;        // byte being sent
        frame_t   rx;        // bits gathered so far
        logic     sclk;
        logic     mosi;
        frame_t   rx_out;    // last completed byte
        logic     rx_valid;
    } eng_state_t;

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign half_end = run && (cnt_q == div);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || half_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: the counter never runs past the programmed half length
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(div)) |-> (cnt_q <= div));

endmodule

// File: rtl/spi_tx_slot.sv
module spi_tx_slot
    import spi_eng_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_valid,
    input  frame_t wr_data,
    output logic   wr_ready,
    input  logic   pop,
    output logic   full,
    output frame_t head
);

    typedef struct packed {
        logic   full;
        frame_t data;
    } slot_t;

    slot_t s_d, s_q;

    assign wr_ready = !s_q.full;
    assign full     = s_q.full;
    assign head     = s_q.data;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.full = 1'b0;
        end
        if (wr_valid && !s_q.full) begin
            s_d.full = 1'b1;
            s_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: the engine only takes a byte that is present
    assert_pop_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> s_q.full);

    // R4: a held byte is not replaced while it waits
    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !pop) |=> (s_q.full && $stable(s_q.data)));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_cpol,
    input  logic   cfg_cpha,
    input  logic   cfg_lsb_first,
    input  logic   half_end,
    input  logic   slot_full,
    input  frame_t slot_data,
    output logic   pop,
    output logic   active,
    output logic   sclk,
    output logic   mosi,
    output frame_t rx_data,
    output logic   rx_valid,
    input  logic   miso
);

    localparam bit_idx_t LAST_BIT = bit_idx_t'(FRAME_BITS - 1);

    eng_state_t st_d, st_q;
    frame_t     rx_next;
    bit_idx_t   cur_pos;
    bit_idx_t   nxt_pos;

    function automatic bit_idx_t wire_pos(input logic lsb, input bit_idx_t b);
        return lsb ? b : (LAST_BIT - b);
    endfunction

    assign active   = st_q.active;
    assign sclk     = st_q.sclk;
    assign mosi     = st_q.mosi;
    assign rx_data  = st_q.rx_out;
    assign rx_valid = st_q.rx_valid;

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        pop           = 1'b0;
        rx_next       = st_q.rx;
        cur_pos       = wire_pos(cfg_lsb_first, st_q.bitn);
        nxt_pos       = wire_pos(cfg_lsb_first, bit_idx_t'(st_q.bitn + 1'b1));

        if (!st_q.active) begin
            st_d.sclk = cfg_cpol;
            if (slot_full) begin
                pop         = 1'b1;
                st_d.active = 1'b1;
                st_d.half   = 1'b0;
                st_d.bitn   = '0;
                st_d.tx     = slot_data;
                if (!cfg_cpha) begin
                    st_d.mosi = slot_data[wire_pos(cfg_lsb_first, '0)];
                end
            end
        end else if (half_end) begin
            if (!st_q.half) begin
                // leading edge
                st_d.half = 1'b1;
                st_d.sclk = !cfg_cpol;
                if (!cfg_cpha) begin
                    st_d.rx[cur_pos] = miso;
                end else begin
                    st_d.mosi = st_q.tx[cur_pos];
                end
            end else begin
                // trailing edge
                st_d.half = 1'b0;
                st_d.sclk = cfg_cpol;
                if (cfg_cpha) begin
                    rx_next[cur_pos] = miso;
                end
                st_d.rx = rx_next;
                if (st_q.bitn == LAST_BIT) begin
                    st_d.rx_out   = rx_next;
                    st_d.rx_valid = 1'b1;
                    if (slot_full) begin
                        pop       = 1'b1;
                        st_d.bitn = '0;
                        st_d.tx   = slot_data;
                        if (!cfg_cpha) begin
                            st_d.mosi = slot_data[wire_pos(cfg_lsb_first, '0)];
                        end
                    end else begin
                        st_d.active = 1'b0;
                    end
                end else begin
                    st_d.bitn = bit_idx_t'(st_q.bitn + 1'b1);
                    if (!cfg_cpha) begin
                        st_d.mosi = st_q.tx[nxt_pos];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a settled idle clock sits at the polarity level
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !st_q.active && $past(!st_q.active)) |-> (st_q.sclk == $past(cfg_cpol)));

    // R7: completion is a single-cycle pulse
    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_valid |=> !st_q.rx_valid);

    // R7: the received byte only changes with a completion pulse
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rx_valid |-> $stable(st_q.rx_out));

    // R8: an idle engine with nothing to load keeps its data line
    assert_idle_mosi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !pop) |=> $stable(st_q.mosi));

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);

    logic   half_end;
    logic   pop;
    logic   slot_full;
    frame_t slot_data;
    logic   active;

    assign busy = active;

    spi_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .div      (cfg_div),
        .half_end (half_end)
    );

    spi_tx_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (tx_valid),
        .wr_data  (tx_data),
        .wr_ready (tx_ready),
        .pop      (pop),
        .full     (slot_full),
        .head     (slot_data)
    );

    spi_shift_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .half_end      (half_end),
        .slot_full     (slot_full),
        .slot_data     (slot_data),
        .pop           (pop),
        .active        (active),
        .sclk          (sclk),
        .mosi          (mosi),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .miso          (miso)
    );

    // R6: a waiting byte at frame end keeps the engine running
    assert_gapless_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(slot_full) && $past(active)) |-> busy);

endmodule

// File: tb/tb_spi_master_engine.sv
`timescale 1ns/1ps
module tb_spi_master_engine;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_cpol = 1'b0;
    logic             cfg_cpha = 1'b0;
    logic             cfg_lsb_first = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             tx_valid = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             tx_ready;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             busy;
    logic             sclk;
    logic             mosi;
    logic             miso = 1'b0;

    spi_master_engine #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // behavioural timing reference
    int m_full = 0, m_act = 0, m_cnt = 0, m_half = 0, m_bit = 0;
    int m_sclk = 0, m_rxv = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    // slave model
    logic [7:0] slv_out = 8'h5a;
    logic [7:0] slv_cap = '0;
    int         slv_k = 0;
    logic       slv_last = 1'b0;
    logic       prev_sclk = 1'b0;

    function automatic int order_pos(input int k);
        return cfg_lsb_first ? k : 7 - k;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int accept;
        int pop;
        if (!rst_n) begin
            m_full = 0; m_act = 0; m_cnt = 0; m_half = 0; m_bit = 0; m_sclk = 0; m_rxv = 0;
        end else begin
            accept = (tx_valid && !m_full) ? 1 : 0;
            pop = 0;
            m_rxv = 0;
            if (!m_act) begin
                m_sclk = cfg_cpol;
                if (m_full) begin
                    pop = 1; m_act = 1; m_half = 0; m_bit = 0; m_cnt = 0;
                end
            end else if (m_cnt < cfg_div) begin
                m_cnt++;
            end else begin
                m_cnt = 0;
                if (m_half == 0) begin
                    m_half = 1; m_sclk = !cfg_cpol;
                end else begin
                    m_half = 0; m_sclk = cfg_cpol;
                    if (m_bit == 7) begin
                        m_rxv = 1;
                        if (m_full) begin pop = 1; m_bit = 0; end
                        else m_act = 0;
                    end else begin
                        m_bit++;
                    end
                end
            end
            if (pop) m_full = 0;
            if (accept) begin m_full = 1; exp_tx.push_back(tx_data); end
        end
    end

    // per-cycle comparison and slave, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3/R1", "sclk", sclk, m_sclk);
            check("R5/R6/R8", "busy", busy, m_act);
            check("R4", "tx_ready", tx_ready, !m_full);
            check("R7", "rx_valid", rx_valid, m_rxv);
            if (sclk != prev_sclk && busy_or_end()) begin
                if ((sclk != cfg_cpol) != cfg_cpha) begin
                    slv_cap[order_pos(slv_k)] = mosi;
                    slv_last = mosi;
                    slv_k++;
                    if (slv_k == 8) begin
                        if (exp_tx.size() == 0) begin
                            check("R4", "unexpected frame", 1, 0);
                        end else begin
                            check("R1/R2", "mosi byte", slv_cap, exp_tx.pop_front());
                        end
                        exp_rx.push_back(slv_out);
                        slv_out = slv_out * 8'd5 + 8'h3b;
                        slv_k = 0;
                    end
                    miso = slv_out[order_pos(slv_k)];
                end
            end
            if (rx_valid) begin
                if (exp_rx.size() == 0) check("R7", "rx without frame", 1, 0);
                else check("R1/R2/R7", "rx_data", rx_data, exp_rx.pop_front());
            end
        end
        prev_sclk = sclk;
    end

    function automatic bit busy_or_end();
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog R5 actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !tx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R1", "idle sclk level", sclk, cfg_cpol);
        check("R8", "idle mosi holds last bit", mosi, slv_last);
    endtask

    task automatic set_cfg(input int mode, input int lsb, input int div);
        @(negedge clk);
        cfg_cpol      = mode[1];
        cfg_cpha      = mode[0];
        cfg_lsb_first = lsb[0];
        cfg_div       = DIV_W'(div);
        slv_k         = 0;
        miso          = slv_out[order_pos(0)];
        @(negedge clk);
        prev_sclk     = sclk;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R9", "reset tx_ready", tx_ready, 1);
        check("R9", "reset busy", busy, 0);
        check("R9", "reset rx_valid", rx_valid, 0);
        check("R9", "reset sclk", sclk, 0);
        check("R9", "reset mosi", mosi, 0);
        check("R9", "reset rx_data", rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_sclk = sclk;

        for (int mode = 0; mode < 4; mode++) begin
            for (int lsb = 0; lsb < 2; lsb++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    set_cfg(mode, lsb, dv * 2);
                    // single byte (R5, R8)
                    send(8'hc3 ^ 8'(mode * 16 + lsb * 4 + dv));
                    wait_idle();
                    // three back-to-back bytes (R6)
                    send(8'h81);
                    send(8'h7e ^ 8'(mode));
                    send(8'h1f);
                    wait_idle();
                end
            end
        end

        // write while full is ignored (R4)
        set_cfg(1, 1, 1);
        send(8'ha5);
        send(8'h3c);
        @(negedge clk);
        check("R4", "slot full before extra write", tx_ready, 0);
        tx_valid = 1'b1;
        tx_data  = 8'hee;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_idle();
        check("R4", "all accepted bytes sent", exp_tx.size(), 0);
        check("R7", "all received bytes seen", exp_rx.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule